// File: doc/BRIEF.md
# Return Address Stack with Checkpoint Repair

This block predicts the targets of subroutine returns in a speculative fetch pipeline. Each call that the front end predicts taken pushes its link address, the call PC plus one 4-byte instruction, onto a circular stack. The current top slot index and the value held there are shown combinationally at all times. A fetch controller that predicts a return reads these two values, keeps them as a checkpoint, and issues a pop in the same cycle. The pop takes effect at the next clock edge.

Wrong-path execution can leave the stack damaged. A restore command repairs it by moving the top pointer back to a checkpointed index and writing the checkpointed target into that slot. Nothing is flushed. A plain pop undoes a single speculative push, for example a call that fell through because the target buffer missed, or a squashed wrong-path call. An external controller decides when each command is issued. The stack holds 16 entries. When it is full, a push overwrites the oldest entry. A pop on an empty stack does nothing.

Top module: `ras_ckpt_stack`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `top_valid` is 0 and `top_idx` is 0.
- R2: A push (with no pop and no restore in the same cycle) moves `top_idx` to the old index plus 1, modulo 16. On the next cycle `top_tgt` shows `push_pc + 4` and `top_valid` is 1.
- R3: `top_idx` and `top_tgt` show the current top with no added latency. A pop on a non-empty stack moves `top_idx` to the old index minus 1, modulo 16, on the next cycle and leaves the slot contents unchanged.
- R4: A pop on an empty stack leaves `top_idx` unchanged, and `top_valid` stays 0.
- R5: The occupancy saturates at 16. Seventeen pushes in a row overwrite the oldest slot. After that, exactly 16 pops are needed to make `top_valid` return to 0.
- R6: A restore sets `top_idx` to `restore_idx` and writes `restore_tgt` into that slot, so on the next cycle `top_tgt` equals `restore_tgt` and `top_valid` is 1. The occupancy is left as it was, except that an empty stack becomes an occupancy of 1.
- R7: When commands arrive in the same cycle, restore wins over pop and pop wins over push. Only the winning command acts, and the losing commands leave no trace.
- R8: A pop issued right after a push brings back the index and target that were on top before the push.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_en | input | 1 | Push the link address of a call |
| push_pc | input | 32 | PC of the call being pushed |
| pop_en | input | 1 | Pop the top entry (return, or undo of a push) |
| restore_en | input | 1 | Rewind the top pointer from a checkpoint |
| restore_idx | input | 4 | Checkpointed top index |
| restore_tgt | input | 32 | Checkpointed top target |
| top_valid | output | 1 | Stack holds at least one entry |
| top_idx | output | 4 | Current top slot index |
| top_tgt | output | 32 | Value held in the top slot |

## Verification
The bench issues simultaneous restore, pop and push commands. A wrong priority order would let the pushed link address or the pop's decrement show up on the top outputs instead of the restored checkpoint. Pops on an empty stack are repeated. A design that underflows would move the pointer or raise `top_valid` again. The bench also pushes seventeen times and then pops back down to empty. A design without saturating occupancy, or with a bad wrap, would drain early, drain late, or return a stale slot value. A restore applied to an empty stack must mark the stack valid; a design that skips this would hide the restored target behind a cleared valid flag.

// File: rtl/ras_pkg.sv
package ras_pkg;

    localparam int RAS_ADDR_W     = 32;
    localparam int RAS_DEPTH      = 16;
    localparam int RAS_INSTR_BYTES = 4;

    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_PUSH    = 2'd1,
        OP_POP     = 2'd2,
        OP_RESTORE = 2'd3
    } ras_op_e;

    // Restore outranks pop, pop outranks push.
    function automatic ras_op_e pick_op(input logic rst_cmd, input logic pop_cmd,
                                        input logic push_cmd);
        if (rst_cmd)       return OP_RESTORE;
        else if (pop_cmd)  return OP_POP;
        else if (push_cmd) return OP_PUSH;
        else               return OP_IDLE;
    endfunction

endpackage

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl
    import ras_pkg::*;
#(
    parameter int DEPTH  = RAS_DEPTH,
    parameter int ADDR_W = RAS_ADDR_W,
    parameter int STEP   = RAS_INSTR_BYTES,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_en,
    input  logic [ADDR_W-1:0] push_pc,
    input  logic              pop_en,
    input  logic              restore_en,
    input  logic [PTR_W-1:0]  restore_idx,
    input  logic [ADDR_W-1:0] restore_tgt,
    output logic [PTR_W-1:0]  top_ptr,
    output logic              not_empty,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_idx,
    output logic [ADDR_W-1:0] wr_data
);

    localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    ras_op_e          op;

    assign op = pick_op(restore_en, pop_en, push_en);

    always_comb begin
        ptr_d   = ptr_q;
        cnt_d   = cnt_q;
        wr_en   = 1'b0;
        wr_idx  = ptr_q;
        wr_data = '0;
        unique case (op)
            OP_RESTORE: begin
                ptr_d   = restore_idx;
                cnt_d   = (cnt_q == '0) ? CNT_W'(1) : cnt_q;
                wr_en   = 1'b1;
                wr_idx  = restore_idx;
                wr_data = restore_tgt;
            end
            OP_POP: begin
                if (cnt_q != '0) begin
                    ptr_d = ptr_q - PTR_ONE;
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            OP_PUSH: begin
                ptr_d   = ptr_q + PTR_ONE;
                cnt_d   = (cnt_q == CNT_FULL) ? cnt_q : cnt_q + CNT_W'(1);
                wr_en   = 1'b1;
                wr_idx  = ptr_q + PTR_ONE;
                wr_data = push_pc + ADDR_W'(STEP);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            cnt_q <= '0;
        end else begin
            ptr_q <= ptr_d;
            cnt_q <= cnt_d;
        end
    end

    assign top_ptr   = ptr_q;
    assign not_empty = (cnt_q != '0);

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_FULL);

    assert_empty_pop_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (pop_en && !restore_en && cnt_q == '0) |=> (ptr_q == $past(ptr_q)) && (cnt_q == '0));

    assert_push_step_R2: assert property (@(posedge clk) disable iff (rst)
        (push_en && !pop_en && !restore_en) |=> ptr_q == $past(ptr_q) + PTR_ONE);

    assert_restore_ptr_R6: assert property (@(posedge clk) disable iff (rst)
        restore_en |=> (ptr_q == $past(restore_idx)) && (cnt_q != '0));

    assert_pop_step_R3: assert property (@(posedge clk) disable iff (rst)
        (pop_en && !restore_en && cnt_q != '0) |=> ptr_q == $past(ptr_q) - PTR_ONE);

endmodule

// File: rtl/ras_store.sv
module ras_store #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_data
);

    logic [ADDR_W-1:0] slot_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[i] <= '0;
            else if (wr_en && wr_idx == PTR_W'(i))
                slot_q[i] <= wr_data;
        end
    end

    assign rd_data = slot_q[rd_idx];

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> slot_q[$past(wr_idx)] == $past(wr_data));

    assert_idle_slot_stable_R3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> slot_q[$past(rd_idx)] == $past(rd_data));

endmodule

// File: rtl/ras_ckpt_stack.sv
module ras_ckpt_stack
    import ras_pkg::*;
#(
    parameter int DEPTH  = RAS_DEPTH,
    parameter int ADDR_W = RAS_ADDR_W,
    parameter int STEP   = RAS_INSTR_BYTES,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_en,
    input  logic [ADDR_W-1:0] push_pc,
    input  logic              pop_en,
    input  logic              restore_en,
    input  logic [PTR_W-1:0]  restore_idx,
    input  logic [ADDR_W-1:0] restore_tgt,
    output logic              top_valid,
    output logic [PTR_W-1:0]  top_idx,
    output logic [ADDR_W-1:0] top_tgt
);

    logic              wr_en;
    logic [PTR_W-1:0]  wr_idx;
    logic [ADDR_W-1:0] wr_data;
    logic [PTR_W-1:0]  ptr;
    logic              live;

    ras_ptr_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .STEP(STEP)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .push_en     (push_en),
        .push_pc     (push_pc),
        .pop_en      (pop_en),
        .restore_en  (restore_en),
        .restore_idx (restore_idx),
        .restore_tgt (restore_tgt),
        .top_ptr     (ptr),
        .not_empty   (live),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_data     (wr_data)
    );

    ras_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (ptr),
        .rd_data (top_tgt)
    );

    assign top_idx   = ptr;
    assign top_valid = live;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> !top_valid && top_idx == '0);

    assert_push_value_R2: assert property (@(posedge clk) disable iff (rst)
        (push_en && !pop_en && !restore_en) |=>
            top_valid && top_tgt == $past(push_pc) + ADDR_W'(STEP));

    assert_restore_value_R6: assert property (@(posedge clk) disable iff (rst)
        restore_en |=> top_valid && top_tgt == $past(restore_tgt));

    assert_pop_beats_push_R7: assert property (@(posedge clk) disable iff (rst)
        (pop_en && push_en && !restore_en) |=> top_idx != $past(top_idx) + PTR_W'(1));

endmodule

// File: tb/ras_ckpt_stack_bench.sv
module ras_ckpt_stack_bench;

    typedef struct packed {
        logic        push;
        logic [31:0] pc;
        logic        pop;
        logic        rest;
        logic [3:0]  ridx;
        logic [31:0] rtgt;
        logic        exp_v;
        logic [3:0]  exp_i;
        logic [31:0] exp_t;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 32'h1000, 1'b0, 1'b0, 4'd0, 32'h0,    1'b1, 4'd1, 32'h1004}, // R2
        '{1'b1, 32'h2000, 1'b0, 1'b0, 4'd0, 32'h0,    1'b1, 4'd2, 32'h2004}, // R2
        '{1'b0, 32'h0,    1'b1, 1'b0, 4'd0, 32'h0,    1'b1, 4'd1, 32'h1004}, // R3
        '{1'b1, 32'h3000, 1'b1, 1'b0, 4'd0, 32'h0,    1'b0, 4'd0, 32'h0},    // R7 pop wins
        '{1'b0, 32'h0,    1'b1, 1'b0, 4'd0, 32'h0,    1'b0, 4'd0, 32'h0},    // R4
        '{1'b1, 32'h3300, 1'b1, 1'b1, 4'd5, 32'hABC0, 1'b1, 4'd5, 32'hABC0}, // R7 restore wins, R6
        '{1'b1, 32'h4000, 1'b0, 1'b0, 4'd0, 32'h0,    1'b1, 4'd6, 32'h4004}, // R2
        '{1'b0, 32'h0,    1'b1, 1'b0, 4'd0, 32'h0,    1'b1, 4'd5, 32'hABC0}, // R8
        '{1'b0, 32'h0,    1'b0, 1'b1, 4'd2, 32'h5550, 1'b1, 4'd2, 32'h5550}, // R6
        '{1'b0, 32'h0,    1'b1, 1'b0, 4'd0, 32'h0,    1'b0, 4'd1, 32'h1004}  // R6 count kept
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        push_en, pop_en, restore_en;
    logic [31:0] push_pc, restore_tgt;
    logic [3:0]  restore_idx;
    logic        top_valid;
    logic [3:0]  top_idx;
    logic [31:0] top_tgt;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    ras_ckpt_stack u_ras_ckpt_stack (
        .clk(clk), .rst(rst), .push_en(push_en), .push_pc(push_pc),
        .pop_en(pop_en), .restore_en(restore_en), .restore_idx(restore_idx),
        .restore_tgt(restore_tgt), .top_valid(top_valid), .top_idx(top_idx),
        .top_tgt(top_tgt)
    );

    task automatic check(input string req, input logic ev, input logic [3:0] ei,
                         input logic [31:0] et, input bit chk_t);
        n_chk++;
        if (top_valid !== ev || top_idx !== ei || (chk_t && top_tgt !== et)) begin
            n_bad++;
            $display("FAIL %s: got valid=%0b idx=%0d tgt=%h, expected valid=%0b idx=%0d tgt=%h",
                     req, top_valid, top_idx, top_tgt, ev, ei, et);
        end
    endtask

    task automatic drive(input logic pu, input logic [31:0] pc, input logic po,
                         input logic re, input logic [3:0] ri, input logic [31:0] rt);
        push_en = pu; push_pc = pc; pop_en = po;
        restore_en = re; restore_idx = ri; restore_tgt = rt;
        @(negedge clk);
        push_en = 1'b0; pop_en = 1'b0; restore_en = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        push_en = 1'b0; pop_en = 1'b0; restore_en = 1'b0;
        push_pc = '0; restore_idx = '0; restore_tgt = '0;
        repeat (2) @(negedge clk);
        check("R1 during reset", 1'b0, 4'd0, 32'h0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", 1'b0, 4'd0, 32'h0, 1'b1);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        for (int k = 0; k < NV; k++) begin
            drive(VEC[k].push, VEC[k].pc, VEC[k].pop, VEC[k].rest, VEC[k].ridx, VEC[k].rtgt);
            check($sformatf("vector %0d", k), VEC[k].exp_v, VEC[k].exp_i, VEC[k].exp_t, 1'b1);
        end

        // R1: reset again after activity
        do_reset();

        // R5: seventeen pushes wrap and overwrite slot 1
        for (int k = 1; k <= 17; k++) drive(1'b1, 32'(k * 256), 1'b0, 1'b0, 4'd0, 32'h0);
        check("R5 wrap top", 1'b1, 4'd1, 32'h1104, 1'b1);
        for (int k = 0; k < 15; k++) drive(1'b0, 32'h0, 1'b1, 1'b0, 4'd0, 32'h0);
        check("R5 one left", 1'b1, 4'd2, 32'h0204, 1'b1);
        drive(1'b0, 32'h0, 1'b1, 1'b0, 4'd0, 32'h0);
        check("R5 drained at 16", 1'b0, 4'd1, 32'h1104, 1'b1);
        drive(1'b0, 32'h0, 1'b1, 1'b0, 4'd0, 32'h0);
        check("R4 extra pop", 1'b0, 4'd1, 32'h1104, 1'b1);

        // R8: push then undo
        drive(1'b1, 32'h7000, 1'b0, 1'b0, 4'd0, 32'h0);
        check("R8 pushed", 1'b1, 4'd2, 32'h7004, 1'b1);
        drive(1'b0, 32'h0, 1'b1, 1'b0, 4'd0, 32'h0);
        check("R8 undone", 1'b0, 4'd1, 32'h1104, 1'b1);

        // R6: restore on empty stack at index 15
        drive(1'b0, 32'h0, 1'b0, 1'b1, 4'd15, 32'h9990);
        check("R6 restore empty", 1'b1, 4'd15, 32'h9990, 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule